// File: doc/BRIEF.md
# Pipeline Interlock and Operand Forwarding Controller

This block is the hazard control for a six-stage in-order integer pipeline whose stages run fetch, issue, decode, execute, memory and write. Register operands are read in decode, and this is also where each source operand's forwarding path is chosen. The block compares the source register specifiers of the decode-stage instruction with the destinations of the two older instructions, which sit in execute and memory. The selects it picks are registered, so they arrive when the instruction enters execute.

The block also detects cases where the instruction in decode cannot move forward. These are a load whose result is needed by the very next instruction, a load/store unit still working through an earlier multi-register transfer, a missing load when the single hit-under-miss slot is already taken, and a multiply that finds the first multiplier stage still occupied. In any of these cases it raises a stall. The stall holds fetch, issue and decode and sends a bubble into execute. A 2-bit code reports the cause of the stall. A flush from branch mispredict detection takes precedence over every stall.

Top module: `hzd_ctrl_top`

## Requirements
- R1: After reset, both forward selects are 0 (register file). With no valid instruction in decode, `stall` is 0, `stall_reason` is 0 and `ex_bubble` is 0.
- R2: Suppose a used decode source equals the execute-stage destination, and that producer has both valid and write-enable set. If no stall or flush occurs, the select for that source is 2 (execute-result path) on the next clock, and `stall` stays 0.
- R3: Suppose a used decode source equals only the memory-stage destination, and that producer has both valid and write-enable set. The select is 1 (memory-result path) on the next clock, with no stall. This includes load data from a load that is two positions ahead.
- R4: When the execute-stage and memory-stage destinations both match the same source, the execute stage wins and the select is 2.
- R5: A producer whose valid or write-enable flag is clear never causes a forward or a stall. The select is then 0.
- R6: A used decode source that matches the destination of a load in execute causes `stall`=1 and `stall_reason`=1 in that cycle, and all selects are 0 on the next clock. Once the load has moved to memory, the same instruction proceeds with select 1, so the stall lasts exactly one cycle.
- R7: A load or store in decode while `lsu_multi_busy` is 1 gives `stall`=1 and `stall_reason`=2.
- R8: A load in decode gives `stall_reason`=2 when `lsu_hum_full` and `lsu_access_miss` are both 1. If only one of these two is 1, there is no stall.
- R9: A multiply in decode while `mul_first_busy` is 1 gives `stall`=1 and `stall_reason`=3.
- R10: When several causes coincide, the reported reason follows a fixed priority: load-use (1) ranks above load/store unit (2), which ranks above multiplier (3).
- R11: `flush`=1 forces `stall`=0 and `stall_reason`=0 even when a hazard is present. It also sets `ex_bubble`=1 and clears all selects on the next clock.
- R12: A source whose used flag is 0 never forwards and never causes a load-use stall.
- R13: `ex_bubble` is 1 exactly when `stall` or `flush` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Mispredict flush of fetch, issue and decode |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_src | input | NSRC x REG_W | Source register specifiers in decode |
| dec_src_used | input | NSRC | Per-source "operand is read" flag |
| dec_is_load | input | 1 | Decode instruction is a load |
| dec_is_store | input | 1 | Decode instruction is a store |
| dec_is_mul | input | 1 | Decode instruction is a multiply |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_dst | input | REG_W | Execute destination register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | Memory stage holds a valid instruction |
| mem_wr_en | input | 1 | Memory instruction writes a register |
| mem_dst | input | REG_W | Memory destination register |
| lsu_multi_busy | input | 1 | Load/store unit busy with a multi-register transfer |
| lsu_hum_full | input | 1 | Hit-under-miss slot occupied |
| lsu_access_miss | input | 1 | The new load misses the data cache |
| mul_first_busy | input | 1 | First multiplier stage occupied |
| stall | output | 1 | Hold fetch, issue and decode |
| ex_bubble | output | 1 | Insert an invalid instruction into execute |
| stall_reason | output | 2 | 0 none, 1 load-use, 2 load/store unit, 3 multiplier |
| ex_fwd_sel | output | NSRC x 2 | Per-source operand path in execute: 0 file, 1 memory, 2 execute |

## Verification
The bench builds the block with REG_W=4 and NSRC=2. With these values every one of the sixteen register specifiers is reachable. Because there are two sources, one instruction can forward on both operands at once, or match on one source while the other is unused. That makes it possible to drive the paired-source cases on their own: both sources forwarding from different stages, and a load-use match that only the unused source would have caused. The scenario sequences cover a load followed by a dependent store, a move followed by an add, back-to-back multiplies, and a flush landing on a hazard.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_FAR  = 2'd1,
    SRC_NEAR = 2'd2
  } opnd_src_e;

  typedef enum logic [1:0] {
    WHY_NONE = 2'd0,
    WHY_LDUSE = 2'd1,
    WHY_LSU  = 2'd2,
    WHY_MUL  = 2'd3
  } stall_why_e;

  // Newest producer wins.
  function automatic opnd_src_e pick_src(input logic hit_near, input logic hit_far);
    if (hit_near)     return SRC_NEAR;
    else if (hit_far) return SRC_FAR;
    else              return SRC_RF;
  endfunction

  // Fixed cause priority.
  function automatic stall_why_e pick_why(input logic lu, input logic ls, input logic mu);
    if (lu)      return WHY_LDUSE;
    else if (ls) return WHY_LSU;
    else if (mu) return WHY_MUL;
    else         return WHY_NONE;
  endfunction

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match
  import hzd_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             dec_valid,
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic             near_valid,
  input  logic             near_wr_en,
  input  logic [REG_W-1:0] near_dst,
  input  logic             near_is_load,
  input  logic             far_valid,
  input  logic             far_wr_en,
  input  logic [REG_W-1:0] far_dst,
  output logic             hit_near,
  output logic             hit_far,
  output logic             load_use,
  output opnd_src_e        sel
);

  function automatic logic writes_reg(input logic v, input logic we,
                                      input logic [REG_W-1:0] dst,
                                      input logic [REG_W-1:0] s);
    return v && we && (dst == s);
  endfunction

  logic reads;
  assign reads    = dec_valid && used;
  assign hit_near = reads && writes_reg(near_valid, near_wr_en, near_dst, src);
  assign hit_far  = reads && writes_reg(far_valid, far_wr_en, far_dst, src);
  assign load_use = hit_near && near_is_load;
  assign sel      = pick_src(hit_near, hit_far);

endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
  import hzd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       dec_valid,
  input  logic       dec_is_load,
  input  logic       dec_is_store,
  input  logic       dec_is_mul,
  input  logic       any_load_use,
  input  logic       lsu_multi_busy,
  input  logic       lsu_hum_full,
  input  logic       lsu_access_miss,
  input  logic       mul_first_busy,
  output logic       stall,
  output logic       ex_bubble,
  output stall_why_e reason
);

  logic evt_lduse, evt_lsu_multi, evt_hum, evt_lsu, evt_mul;

  assign evt_lduse     = any_load_use;
  assign evt_lsu_multi = dec_valid && (dec_is_load || dec_is_store) && lsu_multi_busy;
  assign evt_hum       = dec_valid && dec_is_load && lsu_hum_full && lsu_access_miss;
  assign evt_lsu       = evt_lsu_multi || evt_hum;
  assign evt_mul       = dec_valid && dec_is_mul && mul_first_busy;

  assign reason    = flush ? WHY_NONE : pick_why(evt_lduse, evt_lsu, evt_mul);
  assign stall     = (reason != WHY_NONE);
  assign ex_bubble = stall || flush;

  a_r11_flush_over_stall: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !stall);
  a_r6_load_use_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_lduse && !flush) |-> (stall && reason == WHY_LDUSE));
  a_r10_lsu_over_mul: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_lsu && evt_mul && !evt_lduse && !flush) |-> reason == WHY_LSU);
  a_r9_mul_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (reason == WHY_MUL) |-> (dec_is_mul && mul_first_busy));
  a_r13_bubble_cover: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> (stall || flush));

endmodule

// File: rtl/hzd_sel_reg.sv
module hzd_sel_reg
  import hzd_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_valid,
  input  logic                 ex_bubble,
  input  logic                 near_live,
  input  logic                 far_live,
  input  opnd_src_e            sel_d [NSRC],
  output logic [NSRC-1:0][1:0] sel_q
);

  logic advance;
  assign advance = dec_valid && !ex_bubble;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel_q[i] <= SRC_RF;
      else if (advance) sel_q[i] <= sel_d[i];
      else              sel_q[i] <= SRC_RF;
    end

    a_r6_bubble_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ex_bubble |=> sel_q[i] == SRC_RF);
    a_r2_near_has_producer: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[i] == SRC_NEAR) |-> $past(near_live));
    a_r3_far_has_producer: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[i] == SRC_FAR) |-> $past(far_live));
    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[i] != 2'd3);
  end

endmodule

// File: rtl/hzd_ctrl_top.sv
module hzd_ctrl_top
  import hzd_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int NSRC  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     dec_valid,
  input  logic [NSRC-1:0][REG_W-1:0] dec_src,
  input  logic [NSRC-1:0]          dec_src_used,
  input  logic                     dec_is_load,
  input  logic                     dec_is_store,
  input  logic                     dec_is_mul,
  input  logic                     ex_valid,
  input  logic                     ex_wr_en,
  input  logic [REG_W-1:0]         ex_dst,
  input  logic                     ex_is_load,
  input  logic                     mem_valid,
  input  logic                     mem_wr_en,
  input  logic [REG_W-1:0]         mem_dst,
  input  logic                     lsu_multi_busy,
  input  logic                     lsu_hum_full,
  input  logic                     lsu_access_miss,
  input  logic                     mul_first_busy,
  output logic                     stall,
  output logic                     ex_bubble,
  output logic [1:0]               stall_reason,
  output logic [NSRC-1:0][1:0]     ex_fwd_sel
);

  logic [NSRC-1:0] hit_near, hit_far, lduse;
  opnd_src_e       sel_d [NSRC];
  stall_why_e      why;
  logic            any_lduse, near_live, far_live;

  for (genvar i = 0; i < NSRC; i++) begin : g_match
    hzd_src_match #(.REG_W(REG_W)) u_match (
      .dec_valid    (dec_valid),
      .src          (dec_src[i]),
      .used         (dec_src_used[i]),
      .near_valid   (ex_valid),
      .near_wr_en   (ex_wr_en),
      .near_dst     (ex_dst),
      .near_is_load (ex_is_load),
      .far_valid    (mem_valid),
      .far_wr_en    (mem_wr_en),
      .far_dst      (mem_dst),
      .hit_near     (hit_near[i]),
      .hit_far      (hit_far[i]),
      .load_use     (lduse[i]),
      .sel          (sel_d[i])
    );
  end

  assign any_lduse = |lduse;
  assign near_live = ex_valid && ex_wr_en;
  assign far_live  = mem_valid && mem_wr_en;

  hzd_interlock u_lock (
    .clk             (clk),
    .rst_n           (rst_n),
    .flush           (flush),
    .dec_valid       (dec_valid),
    .dec_is_load     (dec_is_load),
    .dec_is_store    (dec_is_store),
    .dec_is_mul      (dec_is_mul),
    .any_load_use    (any_lduse),
    .lsu_multi_busy  (lsu_multi_busy),
    .lsu_hum_full    (lsu_hum_full),
    .lsu_access_miss (lsu_access_miss),
    .mul_first_busy  (mul_first_busy),
    .stall           (stall),
    .ex_bubble       (ex_bubble),
    .reason          (why)
  );

  assign stall_reason = why;

  hzd_sel_reg #(.NSRC(NSRC)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .ex_bubble (ex_bubble),
    .near_live (near_live),
    .far_live  (far_live),
    .sel_d     (sel_d),
    .sel_q     (ex_fwd_sel)
  );

  a_r12_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_src_used == '0 && !dec_is_load && !dec_is_store && !dec_is_mul) |-> !stall);
  a_r5_dead_producer: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ex_valid && ex_wr_en) && !(mem_valid && mem_wr_en)) |=> ex_fwd_sel == '0);

endmodule

// File: tb/hzd_ctrl_top_tb_top.sv
module hzd_ctrl_top_tb_top;
  localparam int REG_W = 4;
  localparam int NSRC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic flush, dec_valid, dec_is_load, dec_is_store, dec_is_mul;
  logic [NSRC-1:0][REG_W-1:0] dec_src;
  logic [NSRC-1:0] dec_src_used;
  logic ex_valid, ex_wr_en, ex_is_load, mem_valid, mem_wr_en;
  logic [REG_W-1:0] ex_dst, mem_dst;
  logic lsu_multi_busy, lsu_hum_full, lsu_access_miss, mul_first_busy;
  logic stall, ex_bubble;
  logic [1:0] stall_reason;
  logic [NSRC-1:0][1:0] ex_fwd_sel;

  hzd_ctrl_top #(.REG_W(REG_W), .NSRC(NSRC)) dut_i (.*);

  typedef struct {
    string tag;
    logic stall;
    logic bubble;
    logic [1:0] why;
    logic [NSRC-1:0][1:0] sel;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  task automatic clear();
    flush = 0; dec_valid = 0; dec_is_load = 0; dec_is_store = 0; dec_is_mul = 0;
    dec_src = '0; dec_src_used = '0;
    ex_valid = 0; ex_wr_en = 0; ex_dst = '0; ex_is_load = 0;
    mem_valid = 0; mem_wr_en = 0; mem_dst = '0;
    lsu_multi_busy = 0; lsu_hum_full = 0; lsu_access_miss = 0; mul_first_busy = 0;
  endtask

  // Driver: derive expectation from the requirement text, enqueue it.
  task automatic push(input string tag);
    exp_t e;
    logic lu, ls, mu;
    lu = 0;
    e.tag = tag;
    for (int i = 0; i < NSRC; i++) begin
      logic rd, n, f;
      rd = dec_valid & dec_src_used[i];
      n  = rd & ex_valid & ex_wr_en & (ex_dst == dec_src[i]);
      f  = rd & mem_valid & mem_wr_en & (mem_dst == dec_src[i]);
      if (n & ex_is_load) lu = 1;
      e.sel[i] = n ? 2'd2 : (f ? 2'd1 : 2'd0);
    end
    ls = dec_valid & (((dec_is_load | dec_is_store) & lsu_multi_busy) |
                      (dec_is_load & lsu_hum_full & lsu_access_miss));
    mu = dec_valid & dec_is_mul & mul_first_busy;
    if (flush)   e.why = 2'd0;
    else if (lu) e.why = 2'd1;
    else if (ls) e.why = 2'd2;
    else if (mu) e.why = 2'd3;
    else         e.why = 2'd0;
    e.stall  = (e.why != 2'd0);
    e.bubble = e.stall | flush;
    if (e.bubble || !dec_valid) e.sel = '0;
    sb.push_back(e);
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: inputs change at negedge, so just after posedge both the
  // combinational outputs and the freshly registered selects are stable.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "stall", stall, e.stall);
      check(e.tag, "ex_bubble", ex_bubble, e.bubble);
      check(e.tag, "stall_reason", stall_reason, e.why);
      for (int i = 0; i < NSRC; i++)
        check(e.tag, $sformatf("ex_fwd_sel[%0d]", i), ex_fwd_sel[i], e.sel[i]);
    end
  end

  task automatic step_in(input string tag);
    push(tag);
    @(negedge clk);
    clear();
  endtask

  task automatic run_all();
    clear();
    repeat (3) @(negedge clk);
    check("R1", "reset sel0", ex_fwd_sel[0], 0);
    check("R1", "reset sel1", ex_fwd_sel[1], 0);
    rst_n = 1;
    @(negedge clk);
    step_in("R1");

    // R2: mov r0 then dependent add
    ex_valid = 1; ex_wr_en = 1; ex_dst = 4'd0;
    dec_valid = 1; dec_src[0] = 4'd0; dec_src_used = 2'b01; step_in("R2");
    // R3: far producer on source 1, near on source 0 at another register
    ex_valid = 1; ex_wr_en = 1; ex_dst = 4'd7; mem_valid = 1; mem_wr_en = 1; mem_dst = 4'd15;
    dec_valid = 1; dec_src[0] = 4'd7; dec_src[1] = 4'd15; dec_src_used = 2'b11; step_in("R3");
    // R4: both stages write r9
    ex_valid = 1; ex_wr_en = 1; ex_dst = 4'd9; mem_valid = 1; mem_wr_en = 1; mem_dst = 4'd9;
    dec_valid = 1; dec_src[1] = 4'd9; dec_src_used = 2'b10; step_in("R4");
    // R5: write-enable clear, then valid clear
    ex_valid = 1; ex_wr_en = 0; ex_dst = 4'd3; mem_valid = 1; mem_wr_en = 0; mem_dst = 4'd3;
    dec_valid = 1; dec_src[0] = 4'd3; dec_src_used = 2'b01; step_in("R5");
    ex_valid = 0; ex_wr_en = 1; ex_dst = 4'd3; ex_is_load = 1; mem_valid = 0; mem_wr_en = 1; mem_dst = 4'd3;
    dec_valid = 1; dec_src[0] = 4'd3; dec_src_used = 2'b01; step_in("R5");
    // R6: ldr r0 then dependent str; one stall then far forward
    ex_valid = 1; ex_wr_en = 1; ex_is_load = 1; ex_dst = 4'd0;
    dec_valid = 1; dec_is_store = 1; dec_src[0] = 4'd0; dec_src_used = 2'b01; step_in("R6");
    mem_valid = 1; mem_wr_en = 1; mem_dst = 4'd0;
    dec_valid = 1; dec_is_store = 1; dec_src[0] = 4'd0; dec_src_used = 2'b01; step_in("R6");
    // R3: load two ahead forwards without stall
    mem_valid = 1; mem_wr_en = 1; mem_dst = 4'd5; ex_valid = 1; ex_wr_en = 1; ex_dst = 4'd2;
    dec_valid = 1; dec_src[0] = 4'd5; dec_src_used = 2'b01; step_in("R3");
    // R7: store while multi-register transfer active
    lsu_multi_busy = 1; dec_valid = 1; dec_is_store = 1; step_in("R7");
    lsu_multi_busy = 1; dec_valid = 1; dec_is_mul = 1; step_in("R7");
    // R8: HUM slot full with miss, then only one condition
    lsu_hum_full = 1; lsu_access_miss = 1; dec_valid = 1; dec_is_load = 1; step_in("R8");
    lsu_hum_full = 1; lsu_access_miss = 0; dec_valid = 1; dec_is_load = 1; step_in("R8");
    lsu_hum_full = 0; lsu_access_miss = 1; dec_valid = 1; dec_is_load = 1; step_in("R8");
    // R9: two back-to-back multiplies
    mul_first_busy = 1; dec_valid = 1; dec_is_mul = 1; step_in("R9");
    mul_first_busy = 0; dec_valid = 1; dec_is_mul = 1; step_in("R9");
    // R10: priorities
    ex_valid = 1; ex_wr_en = 1; ex_is_load = 1; ex_dst = 4'd6;
    dec_valid = 1; dec_is_load = 1; dec_src[0] = 4'd6; dec_src_used = 2'b01; lsu_multi_busy = 1;
    step_in("R10");
    lsu_multi_busy = 1; mul_first_busy = 1; dec_valid = 1; dec_is_load = 1; dec_is_mul = 1;
    step_in("R10");
    // R11: flush on top of load-use
    flush = 1; ex_valid = 1; ex_wr_en = 1; ex_is_load = 1; ex_dst = 4'd1;
    dec_valid = 1; dec_src[0] = 4'd1; dec_src_used = 2'b01; step_in("R11");
    flush = 1; ex_valid = 1; ex_wr_en = 1; ex_dst = 4'd1;
    dec_valid = 1; dec_src[0] = 4'd1; dec_src_used = 2'b01; step_in("R11");
    // R12: match only on unused source
    ex_valid = 1; ex_wr_en = 1; ex_is_load = 1; ex_dst = 4'd12;
    dec_valid = 1; dec_src[0] = 4'd4; dec_src[1] = 4'd12; dec_src_used = 2'b01; step_in("R12");
    // R13: bubble follows stall and flush; idle decode
    mul_first_busy = 1; dec_valid = 1; dec_is_mul = 1; step_in("R13");
    ex_valid = 1; ex_wr_en = 1; ex_dst = 4'd8; dec_src[0] = 4'd8; dec_src_used = 2'b01; step_in("R1");
    repeat (3) @(negedge clk);
    check("R1", "scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule